// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's pipeline control. It decides, for every clock cycle, whether the core must enter an exception handler, enter an interrupt handler, ask for a system reset, or do nothing. When an entry is taken, the block commits the whole handler-entry state in one registered step. That state is the new status word, the saved status, the saved program counter, the saved stack register, the handler address and the cause registers.

The core presents a level-sensitive pending exception with its cause code, and the interrupt controller presents a request with its priority level, its vector and a vector-valid flag. The core also supplies its current status word, program counter, vector base, register 15 and a flag that marks an instruction in a branch delay slot. One cycle later, `entry_valid` strobes for a cycle with all results, or `reset_req` strobes alone if a blocked exception must be escalated.

Status word bits used: 30 privileged mode, 29 register bank, 28 block, 15 FPU disable, 7:4 interrupt mask.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an accepted interrupt are both pending in the same cycle, the exception is taken, and `intevt_wr` stays low.
- R2: With status bit 28 set, a pending exception whose code is not 0x1E0 raises `reset_req` for one cycle and no entry is taken.
- R3: With status bit 28 set, interrupt requests are ignored, but exception code 0x1E0 is taken normally and vectors to base+0x100.
- R4: An interrupt is accepted only when its level is strictly above status bits 7:4 and the vector-valid flag is high. Otherwise there is no entry.
- R5: On any entry, SSR takes the old status, SGR takes register 15, and the new status has bits 30, 29 and 28 set, with the other bits unchanged except as R7 says.
- R6: An exception taken in a delay slot saves SPC as PC minus 2 and asserts `dslot_clr` with the entry. Without a delay slot SPC equals PC.
- R7: Every exception entry writes its code to EXPEVT. Codes 0x000 and 0x020 are resets: they clear status bit 15, set bits 7:4 to 0xF and jump to 0xA0000000.
- R8: Codes 0x040 and 0x060 (translation miss) vector to base+0x400.
- R9: An interrupt entry vectors to base+0x600, writes the controller's vector to INTEVT and does not write EXPEVT.
- R10: Every other exception code vectors to base+0x100.
- R11: Code 0x160 (trap) saves SPC advanced by 2, applied on top of any delay-slot rewind.
- R12: An interrupt is not accepted while the delay-slot flag is set.
- R13: After reset all strobes are low. Results and strobes appear exactly one cycle after the inputs that cause them, and a strobe lasts one cycle per sampled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_pending | input | 1 | A synchronous exception is pending |
| exc_code | input | 12 | Cause code of the pending exception |
| irq_req | input | 1 | Interrupt controller request |
| irq_level | input | 4 | Priority level of the request |
| irq_vec_ok | input | 1 | Controller has a vector to give |
| irq_vec | input | 12 | Interrupt cause vector |
| in_dslot | input | 1 | Current instruction is in a branch delay slot |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| vbr_in | input | 32 | Vector base |
| r15_in | input | 32 | Current register 15 |
| entry_valid | output | 1 | One-cycle strobe qualifying the entry results |
| reset_req | output | 1 | One-cycle system reset request |
| dslot_clr | output | 1 | Clear the core's delay-slot flag |
| sr_out | output | 32 | New status word |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved program counter |
| sgr_out | output | 32 | Saved register 15 |
| pc_out | output | 32 | Handler address |
| expevt_wr | output | 1 | Write strobe for EXPEVT |
| expevt_out | output | 12 | Exception cause value |
| intevt_wr | output | 1 | Write strobe for INTEVT |
| intevt_out | output | 12 | Interrupt cause value |

## Verification
On every cycle the assertions check the following:
- The exception-over-interrupt priority.
- The escalation of blocked exceptions to a reset request.
- That interrupts are refused at or below the mask and inside a delay slot.
- The saved status and register 15 with the three forced status bits.
- The interrupt handler address and INTEVT value.

Only the bench's scenarios show the following:
- The exact handler address for each exception class.
- The reset-specific status edits.
- The delay-slot and trap adjustments of the saved PC.
- The 0x1E0 exemption.
- That a rejected request leaves every strobe low.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CODE_W   = 12;
    localparam int LVL_W    = 4;

    // status word bit positions
    localparam int SR_MD    = 30;
    localparam int SR_RB    = 29;
    localparam int SR_BL    = 28;
    localparam int SR_FD    = 15;
    localparam int SR_IM_LO = 4;

    // cause codes with special handling
    localparam logic [CODE_W-1:0] C_PWR_RESET  = 12'h000;
    localparam logic [CODE_W-1:0] C_MAN_RESET  = 12'h020;
    localparam logic [CODE_W-1:0] C_TLB_MISS_R = 12'h040;
    localparam logic [CODE_W-1:0] C_TLB_MISS_W = 12'h060;
    localparam logic [CODE_W-1:0] C_TRAP       = 12'h160;
    localparam logic [CODE_W-1:0] C_BL_EXEMPT  = 12'h1E0;

    // handler offsets and reset target
    localparam logic [31:0] OFS_GENERAL = 32'h0000_0100;
    localparam logic [31:0] OFS_TLBMISS = 32'h0000_0400;
    localparam logic [31:0] OFS_IRQ     = 32'h0000_0600;
    localparam logic [31:0] RESET_PC    = 32'hA000_0000;

    typedef enum logic [2:0] {
        K_IDLE,
        K_ESCALATE,
        K_RESET,
        K_TLBMISS,
        K_GENERAL,
        K_TRAP,
        K_IRQ
    } kind_e;

    function automatic kind_e exc_kind(input logic [CODE_W-1:0] code);
        kind_e k;
        unique case (code)
            C_PWR_RESET, C_MAN_RESET:   k = K_RESET;
            C_TLB_MISS_R, C_TLB_MISS_W: k = K_TLBMISS;
            C_TRAP:                     k = K_TRAP;
            default:                    k = K_GENERAL;
        endcase
        return k;
    endfunction

    function automatic logic is_exc(input kind_e k);
        return (k == K_RESET) || (k == K_TLBMISS) ||
               (k == K_GENERAL) || (k == K_TRAP);
    endfunction

endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
    import exc_entry_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int LW = LVL_W
) (
    input  logic          exc_pending,
    input  logic [CW-1:0] exc_code,
    input  logic          irq_req,
    input  logic [LW-1:0] irq_level,
    input  logic          irq_vec_ok,
    input  logic [LW-1:0] imask,
    input  logic          blocked,
    input  logic          in_dslot,
    output kind_e         kind
);

    logic irq_ok;

    // R4 / R12 / R3: acceptance conditions for an interrupt
    assign irq_ok = irq_req && irq_vec_ok && !blocked && !in_dslot &&
                    (irq_level > imask);

    always_comb begin
        kind = K_IDLE;
        if (exc_pending) begin
            // R1: exception wins; R2: blocked exceptions escalate
            if (blocked && (exc_code != CW'(C_BL_EXEMPT)))
                kind = K_ESCALATE;
            else
                kind = exc_kind(CODE_W'(exc_code));
        end else if (irq_ok) begin
            kind = K_IRQ;
        end
    end

endmodule

// File: rtl/exc_entry_vec.sv
module exc_entry_vec
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  kind_e           kind,
    input  logic [XLEN-1:0] sr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] vbr,
    input  logic            in_dslot,
    output logic [XLEN-1:0] new_sr,
    output logic [XLEN-1:0] new_spc,
    output logic [XLEN-1:0] new_pc
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);

    logic [XLEN-1:0] rewound;

    // status word: force block, privileged and bank bits; reset edits more
    always_comb begin
        new_sr          = sr;
        new_sr[SR_MD]   = 1'b1;
        new_sr[SR_RB]   = 1'b1;
        new_sr[SR_BL]   = 1'b1;
        if (kind == K_RESET) begin
            new_sr[SR_FD]                   = 1'b0;
            new_sr[SR_IM_LO +: LVL_W]       = '1;
        end
    end

    // saved PC: delay-slot rewind, then trap advance
    assign rewound = in_dslot ? (pc - INSN_BYTES) : pc;
    assign new_spc = (kind == K_TRAP) ? (rewound + INSN_BYTES) : rewound;

    always_comb begin
        unique case (kind)
            K_RESET:   new_pc = XLEN'(RESET_PC);
            K_TLBMISS: new_pc = vbr + XLEN'(OFS_TLBMISS);
            K_IRQ:     new_pc = vbr + XLEN'(OFS_IRQ);
            default:   new_pc = vbr + XLEN'(OFS_GENERAL);
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = CODE_W,
    parameter int LW   = LVL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_pending,
    input  logic [CW-1:0]   exc_code,
    input  logic            irq_req,
    input  logic [LW-1:0]   irq_level,
    input  logic            irq_vec_ok,
    input  logic [CW-1:0]   irq_vec,
    input  logic            in_dslot,
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] vbr_in,
    input  logic [XLEN-1:0] r15_in,
    output logic            entry_valid,
    output logic            reset_req,
    output logic            dslot_clr,
    output logic [XLEN-1:0] sr_out,
    output logic [XLEN-1:0] ssr_out,
    output logic [XLEN-1:0] spc_out,
    output logic [XLEN-1:0] sgr_out,
    output logic [XLEN-1:0] pc_out,
    output logic            expevt_wr,
    output logic [CW-1:0]   expevt_out,
    output logic            intevt_wr,
    output logic [CW-1:0]   intevt_out
);

    kind_e           kind;
    logic [XLEN-1:0] nxt_sr, nxt_spc, nxt_pc;
    logic            take_exc, take_irq;

    exc_entry_arb #(.CW(CW), .LW(LW)) u_arb (
        .exc_pending (exc_pending),
        .exc_code    (exc_code),
        .irq_req     (irq_req),
        .irq_level   (irq_level),
        .irq_vec_ok  (irq_vec_ok),
        .imask       (sr_in[SR_IM_LO +: LW]),
        .blocked     (sr_in[SR_BL]),
        .in_dslot    (in_dslot),
        .kind        (kind)
    );

    exc_entry_vec #(.XLEN(XLEN)) u_vec (
        .kind     (kind),
        .sr       (sr_in),
        .pc       (pc_in),
        .vbr      (vbr_in),
        .in_dslot (in_dslot),
        .new_sr   (nxt_sr),
        .new_spc  (nxt_spc),
        .new_pc   (nxt_pc)
    );

    assign take_exc = is_exc(kind);
    assign take_irq = (kind == K_IRQ);

    // strobes: one per sampled request (R13)
    always_ff @(posedge clk) begin
        if (rst) begin
            entry_valid <= 1'b0;
            reset_req   <= 1'b0;
            dslot_clr   <= 1'b0;
            expevt_wr   <= 1'b0;
            intevt_wr   <= 1'b0;
        end else begin
            entry_valid <= take_exc || take_irq;
            reset_req   <= (kind == K_ESCALATE);
            dslot_clr   <= take_exc && in_dslot;
            expevt_wr   <= take_exc;
            intevt_wr   <= take_irq;
        end
    end

    // committed entry state, held between entries
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_out     <= '0;
            ssr_out    <= '0;
            spc_out    <= '0;
            sgr_out    <= '0;
            pc_out     <= '0;
            expevt_out <= '0;
            intevt_out <= '0;
        end else if (take_exc || take_irq) begin
            sr_out  <= nxt_sr;
            ssr_out <= sr_in;
            spc_out <= nxt_spc;
            sgr_out <= r15_in;
            pc_out  <= nxt_pc;
            if (take_exc) expevt_out <= exc_code;
            if (take_irq) intevt_out <= irq_vec;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = CODE_W,
    parameter int LW   = LVL_W
) (
    input logic            clk,
    input logic            rst,
    input logic            exc_pending,
    input logic [CW-1:0]   exc_code,
    input logic [LW-1:0]   irq_level,
    input logic            irq_vec_ok,
    input logic [CW-1:0]   irq_vec,
    input logic            in_dslot,
    input logic [XLEN-1:0] sr_in,
    input logic [XLEN-1:0] vbr_in,
    input logic [XLEN-1:0] r15_in,
    input logic            entry_valid,
    input logic            reset_req,
    input logic [XLEN-1:0] sr_out,
    input logic [XLEN-1:0] ssr_out,
    input logic [XLEN-1:0] sgr_out,
    input logic [XLEN-1:0] pc_out,
    input logic            expevt_wr,
    input logic            intevt_wr,
    input logic [CW-1:0]   intevt_out
);

    a_r1_exc_first: assert property (@(posedge clk) disable iff (rst)
        intevt_wr |-> !$past(exc_pending));

    a_r2_no_entry: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> !entry_valid);

    a_r2_escalate: assert property (@(posedge clk) disable iff (rst)
        ($past(exc_pending) && $past(sr_in[SR_BL]) &&
         ($past(exc_code) != CW'(C_BL_EXEMPT))) |-> reset_req);

    a_r3_bl_irq: assert property (@(posedge clk) disable iff (rst)
        intevt_wr |-> !$past(sr_in[SR_BL]));

    a_r4_level: assert property (@(posedge clk) disable iff (rst)
        intevt_wr |-> ($past(irq_level) > $past(sr_in[SR_IM_LO +: LW])) &&
                      $past(irq_vec_ok));

    a_r5_saved: assert property (@(posedge clk) disable iff (rst)
        entry_valid |-> (sr_out[SR_BL] && sr_out[SR_MD] && sr_out[SR_RB] &&
                         ssr_out == $past(sr_in) && sgr_out == $past(r15_in)));

    a_r9_irq_entry: assert property (@(posedge clk) disable iff (rst)
        intevt_wr |-> (pc_out == $past(vbr_in) + XLEN'(OFS_IRQ)) &&
                      !expevt_wr && (intevt_out == $past(irq_vec)));

    a_r12_dslot: assert property (@(posedge clk) disable iff (rst)
        intevt_wr |-> !$past(in_dslot));

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CW(CW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .exc_pending (exc_pending),
    .exc_code    (exc_code),
    .irq_level   (irq_level),
    .irq_vec_ok  (irq_vec_ok),
    .irq_vec     (irq_vec),
    .in_dslot    (in_dslot),
    .sr_in       (sr_in),
    .vbr_in      (vbr_in),
    .r15_in      (r15_in),
    .entry_valid (entry_valid),
    .reset_req   (reset_req),
    .sr_out      (sr_out),
    .ssr_out     (ssr_out),
    .sgr_out     (sgr_out),
    .pc_out      (pc_out),
    .expevt_wr   (expevt_wr),
    .intevt_wr   (intevt_wr),
    .intevt_out  (intevt_out)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_pending = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_level = '0;
    logic        irq_vec_ok = 1'b0;
    logic [11:0] irq_vec = '0;
    logic        in_dslot = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, vbr_in = '0, r15_in = '0;
    logic        entry_valid, reset_req, dslot_clr, expevt_wr, intevt_wr;
    logic [31:0] sr_out, ssr_out, spc_out, sgr_out, pc_out;
    logic [11:0] expevt_out, intevt_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst(rst), .exc_pending(exc_pending), .exc_code(exc_code),
        .irq_req(irq_req), .irq_level(irq_level), .irq_vec_ok(irq_vec_ok),
        .irq_vec(irq_vec), .in_dslot(in_dslot), .sr_in(sr_in), .pc_in(pc_in),
        .vbr_in(vbr_in), .r15_in(r15_in), .entry_valid(entry_valid),
        .reset_req(reset_req), .dslot_clr(dslot_clr), .sr_out(sr_out),
        .ssr_out(ssr_out), .spc_out(spc_out), .sgr_out(sgr_out),
        .pc_out(pc_out), .expevt_wr(expevt_wr), .expevt_out(expevt_out),
        .intevt_wr(intevt_wr), .intevt_out(intevt_out)
    );

    typedef struct {
        string       tag;
        bit          ent, rrq, dsc, ew, iw;
        logic [31:0] sr, ssr, spc, sgr, pc;
        logic [11:0] ev, iv;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string tag, input bit ok, input string got,
                         input string want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got %s expected %s", tag, got, want);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected result
    task automatic drive(input string tag, input bit ex, input logic [11:0] code,
                         input bit irq, input logic [3:0] lvl, input bit vok,
                         input logic [11:0] vec, input bit ds,
                         input logic [31:0] sr, input logic [31:0] pc);
        exp_t e;
        bit blk, irq_ok;
        @(negedge clk);
        exc_pending = ex; exc_code = code; irq_req = irq; irq_level = lvl;
        irq_vec_ok = vok; irq_vec = vec; in_dslot = ds; sr_in = sr; pc_in = pc;
        vbr_in = 32'h8C00_0000; r15_in = 32'h1234_5678 ^ pc;
        e.tag = tag;
        blk = sr[28];
        irq_ok = irq && vok && !blk && !ds && (lvl > sr[7:4]);
        e.rrq = ex && blk && (code != 12'h1E0);
        e.ent = (ex && !e.rrq) || (!ex && irq_ok);
        e.ew  = ex && !e.rrq;
        e.iw  = !ex && irq_ok;
        e.dsc = e.ew && ds;
        e.ssr = sr;
        e.sgr = r15_in;
        e.sr  = sr | 32'h7000_0000;
        e.spc = pc;
        if (ds) e.spc = pc - 2;
        if (code == 12'h160) e.spc = e.spc + 2;
        e.ev = code;
        e.iv = vec;
        if (e.iw) e.pc = vbr_in + 32'h600;
        else if (code == 12'h000 || code == 12'h020) begin
            e.pc = 32'hA000_0000;
            e.sr = (e.sr & ~32'h0000_8000) | 32'h0000_00F0;
        end
        else if (code == 12'h040 || code == 12'h060) e.pc = vbr_in + 32'h400;
        else e.pc = vbr_in + 32'h100;
        sb.push_back(e);
    endtask

    // monitor: compare just after the edge that registers each result
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " strobes"},
                  {entry_valid, reset_req, dslot_clr, expevt_wr, intevt_wr} ==
                  {e.ent, e.rrq, e.dsc, e.ew, e.iw},
                  $sformatf("%b", {entry_valid, reset_req, dslot_clr, expevt_wr, intevt_wr}),
                  $sformatf("%b", {e.ent, e.rrq, e.dsc, e.ew, e.iw}));
            if (e.ent) begin
                check({e.tag, " state"},
                      sr_out == e.sr && ssr_out == e.ssr && spc_out == e.spc &&
                      sgr_out == e.sgr && pc_out == e.pc,
                      $sformatf("sr=%h ssr=%h spc=%h sgr=%h pc=%h",
                                sr_out, ssr_out, spc_out, sgr_out, pc_out),
                      $sformatf("sr=%h ssr=%h spc=%h sgr=%h pc=%h",
                                e.sr, e.ssr, e.spc, e.sgr, e.pc));
                if (e.ew) check({e.tag, " expevt"}, expevt_out == e.ev,
                                $sformatf("%h", expevt_out), $sformatf("%h", e.ev));
                if (e.iw) check({e.tag, " intevt"}, intevt_out == e.iv,
                                $sformatf("%h", intevt_out), $sformatf("%h", e.iv));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R13 reset state", {entry_valid, reset_req, expevt_wr, intevt_wr} == 4'b0,
              $sformatf("%b", {entry_valid, reset_req, expevt_wr, intevt_wr}), "0000");
        drive("R13 idle",          0, 12'h000, 0, 4'h0, 0, 12'h000, 0, 32'h0000_0000, 32'h1000);
        drive("R10 general",       1, 12'h180, 0, 4'h0, 0, 12'h000, 0, 32'h0000_0030, 32'h1004);
        drive("R8 miss read",      1, 12'h040, 0, 4'h0, 0, 12'h000, 0, 32'h0000_0001, 32'h1008);
        drive("R8 miss write",     1, 12'h060, 0, 4'h0, 0, 12'h000, 0, 32'h4000_0000, 32'h100C);
        drive("R11 trap",          1, 12'h160, 0, 4'h0, 0, 12'h000, 0, 32'h0000_0000, 32'h2000);
        drive("R11 trap dslot",    1, 12'h160, 0, 4'h0, 0, 12'h000, 1, 32'h0000_0000, 32'h2010);
        drive("R6 dslot exc",      1, 12'h0E0, 0, 4'h0, 0, 12'h000, 1, 32'h0000_0000, 32'h2020);
        drive("R7 power reset",    1, 12'h000, 0, 4'h0, 0, 12'h000, 0, 32'h0000_8020, 32'h3000);
        drive("R7 manual reset",   1, 12'h020, 0, 4'h0, 0, 12'h000, 0, 32'h0000_8000, 32'h3004);
        drive("R9 irq taken",      0, 12'h000, 1, 4'h9, 1, 12'h3A0, 0, 32'h0000_0030, 32'h4000);
        drive("R4 level equal",    0, 12'h000, 1, 4'h3, 1, 12'h3A0, 0, 32'h0000_0030, 32'h4004);
        drive("R4 no vector",      0, 12'h000, 1, 4'hF, 0, 12'h3A0, 0, 32'h0000_0000, 32'h4008);
        drive("R4 level above",    0, 12'h000, 1, 4'h4, 1, 12'h240, 0, 32'h0000_0030, 32'h400C);
        drive("R12 irq in dslot",  0, 12'h000, 1, 4'hF, 1, 12'h3A0, 1, 32'h0000_0000, 32'h4010);
        drive("R1 exc beats irq",  1, 12'h180, 1, 4'hF, 1, 12'h3A0, 0, 32'h0000_0000, 32'h5000);
        drive("R2 escalate",       1, 12'h0A0, 0, 4'h0, 0, 12'h000, 0, 32'h1000_0000, 32'h6000);
        drive("R2 escalate reset", 1, 12'h000, 0, 4'h0, 0, 12'h000, 0, 32'h1000_0000, 32'h6004);
        drive("R3 exempt code",    1, 12'h1E0, 0, 4'h0, 0, 12'h000, 0, 32'h1000_0000, 32'h6008);
        drive("R3 blocked irq",    0, 12'h000, 1, 4'hF, 1, 12'h3A0, 0, 32'h1000_0000, 32'h600C);
        drive("R5 saved regs",     1, 12'h100, 0, 4'h0, 0, 12'h000, 0, 32'h0F0F_F0F3, 32'h7000);
        drive("R13 idle after",    0, 12'h000, 0, 4'h0, 0, 12'h000, 0, 32'h0000_0000, 32'h7004);
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got timeout expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule